// File: doc/BRIEF.md
# DRAM Bank Row-Timing Guard

This block watches the command stream going to a DRAM device with eight banks. It records whether each bank has a row open and how long ago that bank was last opened and last closed. It flags any command that would break a minimum row-timing rule or that does not match the bank's open or closed state. It sits beside a memory controller's command path as a checker and readiness oracle. It never changes the commands it sees.

Each cycle the guard decodes one strobed command from four active-low control levels and a bank address. It compares the addressed bank's age counters against four cycle limits: open-to-column, close-to-open, open-to-close, and open-to-open. The limits come from a five-entry speed-bin table, selected by an input. The guard pulses an error flag after an illegal command. It also publishes, for every bank, registered flags that say whether an open, a column access or a close would be accepted in the current cycle.

Top module: `bank_timing_guard`

## Requirements
- R1: The command is decoded from the levels {row_n, col_n, wen_n}. 011 opens a row, 101 reads, 100 writes and 010 closes the row. Every other code (000, 001, 110, 111) has no effect on any bank and never raises the error.
- R2: A command sampled with sel_n high, or with cmd_valid low, is treated as no operation. It changes no bank state and raises no error.
- R3: There are eight banks, addressed by the 3-bit bank_sel. A command touches only the addressed bank, and each bank keeps its own state and timers.
- R4: A read or write to an open bank is legal once at least tRCD cycles have passed since that bank was opened. A read or write issued after tRCD-1 cycles raises the error.
- R5: A close to an open bank is legal after at least tRAS cycles since it was opened, and the bank becomes closed. A close issued earlier raises the error. A close to an already closed bank is accepted and changes nothing.
- R6: An open to a closed bank needs at least tRP cycles since its last close and at least tRC cycles since its last open. An earlier open raises the error.
- R7: A read or write to a closed bank, an open to an open bank, or any rule-breaking command raises the error and leaves the bank's state and timers unchanged.
- R8: err is registered. It is high in the cycle after an illegal command and low in the cycle after a legal one or no command.
- R9: The limits in cycles are the ceiling of the time in picoseconds divided by the clock period. There are five bins, indexed by speed_bin:
  - bin 0: period 1875 ps, tRCD and tRP 13125 ps, tRAS 37500 ps.
  - bin 1: period 1500 ps, tRCD and tRP 13500 ps, tRAS 36000 ps.
  - bin 2: period 1250 ps, tRCD and tRP 13750 ps, tRAS 35000 ps.
  - bin 3: period 1100 ps, tRCD and tRP 13200 ps, tRAS 34000 ps.
  - bin 4: period 1000 ps, tRCD and tRP 13000 ps, tRAS 33000 ps.
  
  In every bin tRC = tRAS + tRP in time. speed_bin values 5 to 7 select bin 4, and a new value governs checks from the next cycle.
- R10: act_rdy[i], rw_rdy[i] and pre_rdy[i] are registered. In each cycle they equal whether an open, a read or write, or a close to bank i issued in that cycle would be accepted.
- R11: After reset all banks are closed, with their timers expired. act_rdy and pre_rdy are all ones, rw_rdy is all zeros, and err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| sel_n | input | 1 | Active-low device select; high masks the command |
| row_n | input | 1 | Active-low row strobe level |
| col_n | input | 1 | Active-low column strobe level |
| wen_n | input | 1 | Active-low write-enable level |
| bank_sel | input | 3 | Addressed bank |
| speed_bin | input | 3 | Speed-bin select for the timing limits |
| act_rdy | output | 8 | Per bank: an open would be accepted now |
| rw_rdy | output | 8 | Per bank: a read or write would be accepted now |
| pre_rdy | output | 8 | Per bank: a close would be accepted now |
| err | output | 1 | One-cycle pulse after an illegal command |

## Verification
The bench sweeps every speed_bin value across all eight banks. In each case it places a read, a close and an open one cycle before their limit and again exactly at the limit. This separates an off-by-one in each counter comparison and a wrong table entry per bin. Repeated opens, close-then-read, and column accesses to a neighbouring closed bank tell state-update faults apart from timing faults and expose any leakage between banks. Masked commands and the four unused codes are issued ahead of opens that must still succeed, which shows that they left no trace.

// File: rtl/bt_pkg.sv
package bt_pkg;

  parameter int LIM_W    = 7;
  parameter int NUM_BINS = 5;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4
  } cmd_e;

  typedef struct packed {
    logic [LIM_W-1:0] trcd;
    logic [LIM_W-1:0] trp;
    logic [LIM_W-1:0] tras;
    logic [LIM_W-1:0] trc;
  } lim_t;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  // Limits in cycles for one bin, derived from picosecond values.
  function automatic lim_t bin_limits(input int unsigned idx);
    int unsigned tck;
    int unsigned rcd;
    int unsigned ras;
    lim_t        l;
    case (idx)
      0:       begin tck = 1875; rcd = 13125; ras = 37500; end
      1:       begin tck = 1500; rcd = 13500; ras = 36000; end
      2:       begin tck = 1250; rcd = 13750; ras = 35000; end
      3:       begin tck = 1100; rcd = 13200; ras = 34000; end
      default: begin tck = 1000; rcd = 13000; ras = 33000; end
    endcase
    l.trcd = LIM_W'(ceil_div(rcd, tck));
    l.trp  = LIM_W'(ceil_div(rcd, tck));
    l.tras = LIM_W'(ceil_div(ras, tck));
    l.trc  = LIM_W'(ceil_div(ras + rcd, tck));
    return l;
  endfunction

  function automatic logic [LIM_W-1:0] sat_inc(input logic [LIM_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

endpackage

// File: rtl/bt_cmd_decode.sv
module bt_cmd_decode
  import bt_pkg::*;
(
  input  logic cmd_valid,
  input  logic sel_n,
  input  logic row_n,
  input  logic col_n,
  input  logic wen_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NONE;
    if (cmd_valid && !sel_n) begin
      case ({row_n, col_n, wen_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/bt_speed_table.sv
module bt_speed_table
  import bt_pkg::*;
#(
  parameter int BIN_W = 3
) (
  input  logic             clk,
  input  logic [BIN_W-1:0] speed_bin,
  output lim_t             lim_d,
  output lim_t             lim_q
);

  localparam int IDX_W = $clog2(NUM_BINS);

  lim_t            table_q [NUM_BINS];
  logic [IDX_W-1:0] idx;

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    assign table_q[b] = bin_limits(b);
  end

  always_comb begin
    if (int'(speed_bin) >= NUM_BINS) idx = IDX_W'(NUM_BINS - 1);
    else                             idx = IDX_W'(speed_bin);
  end

  assign lim_d = table_q[idx];

  always_ff @(posedge clk) begin
    lim_q <= lim_d;
  end

endmodule

// File: rtl/bt_bank_track.sv
module bt_bank_track
  import bt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  cmd_e cmd,
  input  lim_t lim_q,
  input  lim_t lim_d,
  output logic bad,
  output logic act_rdy,
  output logic rw_rdy,
  output logic pre_rdy
);

  logic             open_q, open_d;
  logic [LIM_W-1:0] act_cnt, act_cnt_d;
  logic [LIM_W-1:0] pre_cnt, pre_cnt_d;
  logic             act_ok, rw_ok, pre_ok;
  logic             do_act, do_pre;
  logic             is_rw;

  assign is_rw  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign act_ok = !open_q && (pre_cnt >= lim_q.trp) && (act_cnt >= lim_q.trc);
  assign rw_ok  = open_q && (act_cnt >= lim_q.trcd);
  assign pre_ok = !open_q || (act_cnt >= lim_q.tras);

  assign bad = hit && (((cmd == CMD_ACT) && !act_ok) ||
                       (is_rw && !rw_ok) ||
                       ((cmd == CMD_PRE) && !pre_ok));

  assign do_act = hit && (cmd == CMD_ACT) && act_ok;
  assign do_pre = hit && (cmd == CMD_PRE) && open_q && pre_ok;

  always_comb begin
    open_d    = open_q;
    act_cnt_d = sat_inc(act_cnt);
    pre_cnt_d = sat_inc(pre_cnt);
    if (do_act) begin
      open_d    = 1'b1;
      act_cnt_d = LIM_W'(1);
    end
    if (do_pre) begin
      open_d    = 1'b0;
      pre_cnt_d = LIM_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      act_cnt <= '1;
      pre_cnt <= '1;
      act_rdy <= 1'b1;
      rw_rdy  <= 1'b0;
      pre_rdy <= 1'b1;
    end else begin
      open_q  <= open_d;
      act_cnt <= act_cnt_d;
      pre_cnt <= pre_cnt_d;
      act_rdy <= !open_d && (pre_cnt_d >= lim_d.trp) && (act_cnt_d >= lim_d.trc);
      rw_rdy  <= open_d && (act_cnt_d >= lim_d.trcd);
      pre_rdy <= !open_d || (act_cnt_d >= lim_d.tras);
    end
  end

  // R7
  open_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(open_q) |-> $past(hit && (cmd == CMD_ACT)));

  // R5
  open_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(open_q) |-> $past(hit && (cmd == CMD_PRE)));

  // R4
  age_restart_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(open_q) |-> (act_cnt == LIM_W'(1)));

  // R10
  rdy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(act_rdy && rw_rdy));

endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard
  import bt_pkg::*;
#(
  parameter int BANKS = 8,
  parameter int BIN_W = 3,
  localparam int BA_W = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             sel_n,
  input  logic             row_n,
  input  logic             col_n,
  input  logic             wen_n,
  input  logic [BA_W-1:0]  bank_sel,
  input  logic [BIN_W-1:0] speed_bin,
  output logic [BANKS-1:0] act_rdy,
  output logic [BANKS-1:0] rw_rdy,
  output logic [BANKS-1:0] pre_rdy,
  output logic             err
);

  cmd_e             cmd;
  lim_t             lim_d, lim_q;
  logic [BANKS-1:0] hit_vec;
  logic [BANKS-1:0] bad_vec;

  bt_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .sel_n     (sel_n),
    .row_n     (row_n),
    .col_n     (col_n),
    .wen_n     (wen_n),
    .cmd       (cmd)
  );

  bt_speed_table #(.BIN_W(BIN_W)) u_tbl (
    .clk       (clk),
    .speed_bin (speed_bin),
    .lim_d     (lim_d),
    .lim_q     (lim_q)
  );

  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    assign hit_vec[i] = (cmd != CMD_NONE) && (bank_sel == BA_W'(i));

    bt_bank_track u_trk (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit_vec[i]),
      .cmd     (cmd),
      .lim_q   (lim_q),
      .lim_d   (lim_d),
      .bad     (bad_vec[i]),
      .act_rdy (act_rdy[i]),
      .rw_rdy  (rw_rdy[i]),
      .pre_rdy (pre_rdy[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= |bad_vec;
  end

  // R3
  hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(cmd != CMD_NONE));

  // R2
  mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_n || !cmd_valid) |=> !err);

endmodule

// File: tb/sim_bank_timing_guard.sv
`timescale 1ns/1ps
module sim_bank_timing_guard;

  localparam logic [2:0] C_ACT = 3'b011;
  localparam logic [2:0] C_RD  = 3'b101;
  localparam logic [2:0] C_WR  = 3'b100;
  localparam logic [2:0] C_PRE = 3'b010;
  localparam logic [2:0] C_REF = 3'b001;
  localparam logic [2:0] C_MRS = 3'b000;
  localparam logic [2:0] C_ZQ  = 3'b110;
  localparam logic [2:0] C_NOP = 3'b111;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       sel_n = 1'b1;
  logic       row_n = 1'b1;
  logic       col_n = 1'b1;
  logic       wen_n = 1'b1;
  logic [2:0] bank_sel = '0;
  logic [2:0] speed_bin = '0;
  logic [7:0] act_rdy, rw_rdy, pre_rdy;
  logic       err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int trcd, trp, tras;

  always #2 clk = ~clk;

  bank_timing_guard u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .sel_n(sel_n),
    .row_n(row_n), .col_n(col_n), .wen_n(wen_n), .bank_sel(bank_sel),
    .speed_bin(speed_bin), .act_rdy(act_rdy), .rw_rdy(rw_rdy),
    .pre_rdy(pre_rdy), .err(err)
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic set_limits(input int b);
    int tck, rcd, ras;
    int idx;
    idx = (b > 4) ? 4 : b;
    case (idx)
      0: begin tck = 1875; rcd = 13125; ras = 37500; end
      1: begin tck = 1500; rcd = 13500; ras = 36000; end
      2: begin tck = 1250; rcd = 13750; ras = 35000; end
      3: begin tck = 1100; rcd = 13200; ras = 34000; end
      default: begin tck = 1000; rcd = 13000; ras = 33000; end
    endcase
    trcd = (rcd + tck - 1) / tck;
    trp  = trcd;
    tras = (ras + tck - 1) / tck;
  endtask

  task automatic do_raw(input logic v, input logic s, input logic [2:0] code,
                        input int bk, input logic exp_err, input string tag);
    @(negedge clk);
    if (v && !s) begin
      case (code)
        C_ACT: chk(act_rdy[bk], !exp_err, {tag, " act_rdy (R10)"});
        C_RD, C_WR: chk(rw_rdy[bk], !exp_err, {tag, " rw_rdy (R10)"});
        C_PRE: chk(pre_rdy[bk], !exp_err, {tag, " pre_rdy (R10)"});
        default: ;
      endcase
    end
    cmd_valid = v;
    sel_n = s;
    {row_n, col_n, wen_n} = code;
    bank_sel = 3'(bk);
    @(posedge clk);
    #1;
    chk(err, exp_err, {tag, " err (R8)"});
    cmd_valid = 1'b0;
    sel_n = 1'b1;
    {row_n, col_n, wen_n} = C_NOP;
  endtask

  task automatic do_cmd(input logic [2:0] code, input int bk, input logic exp_err,
                        input string tag);
    do_raw(1'b1, 1'b0, code, bk, exp_err, tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
    end
  endtask

  task automatic bank_run(input int bk);
    int ob;
    logic [2:0] rw;
    ob = (bk + 1) % 8;
    rw = bk[0] ? C_WR : C_RD;
    do_cmd(C_ACT, bk, 1'b0, "R6 open closed bank");
    do_cmd(C_ACT, bk, 1'b1, "R7 open on open bank");
    idle(trcd - 3);
    do_cmd(rw, bk, 1'b1, "R4 column at tRCD-1");
    do_cmd(rw, bk, 1'b0, "R4 column at tRCD");
    do_cmd(C_RD, ob, 1'b1, "R3 neighbour stays closed");
    idle(tras - trcd - 3);
    do_cmd(C_PRE, bk, 1'b1, "R5 close at tRAS-1");
    do_cmd(C_PRE, bk, 1'b0, "R5 close at tRAS");
    do_cmd(C_PRE, bk, 1'b0, "R5 close of closed bank");
    do_cmd(rw, bk, 1'b1, "R7 column to closed bank");
    idle(trp - 4);
    do_cmd(C_ACT, bk, 1'b1, "R6 open at tRP-1");
    do_cmd(C_ACT, bk, 1'b0, "R6 open at tRP");
    idle(tras - 1);
    do_cmd(C_PRE, bk, 1'b0, "R5 final close");
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    set_limits(0);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(act_rdy, 8'hff, "R11 act_rdy after reset");
    chk(rw_rdy, 8'h00, "R11 rw_rdy after reset");
    chk(pre_rdy, 8'hff, "R11 pre_rdy after reset");
    chk(err, 0, "R11 err after reset");

    // R1: unused codes leave banks untouched
    do_cmd(C_REF, 0, 1'b0, "R1 code 001");
    do_cmd(C_MRS, 0, 1'b0, "R1 code 000");
    do_cmd(C_ZQ, 0, 1'b0, "R1 code 110");
    do_cmd(C_NOP, 0, 1'b0, "R1 code 111");
    do_cmd(C_ACT, 0, 1'b0, "R1 open after unused codes");
    do_cmd(C_REF, 0, 1'b0, "R1 code 001 on open bank");
    do_cmd(C_ACT, 0, 1'b1, "R1 bank still open");
    idle(tras - 3);
    do_cmd(C_PRE, 0, 1'b0, "R1 close");

    // R2: masked commands
    do_raw(1'b1, 1'b1, C_ACT, 1, 1'b0, "R2 open with select high");
    do_raw(1'b0, 1'b0, C_ACT, 1, 1'b0, "R2 open without strobe");
    do_raw(1'b1, 1'b1, C_RD, 2, 1'b0, "R2 masked read to closed bank");
    do_cmd(C_ACT, 1, 1'b0, "R2 open after masked opens");
    idle(tras - 1);
    do_cmd(C_PRE, 1, 1'b0, "R2 close");
    idle(trp);

    // R9: sweep every bin value across every bank
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      speed_bin = 3'(b);
      set_limits(b);
      idle(2);
      for (int bk = 0; bk < 8; bk++) begin
        bank_run(bk);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule